// File: doc/BRIEF.md
# Exact Fixed-Point Multiply-Accumulate Unit

This unit accumulates a stream of floating-point products with no rounding error. Each accepted pair of operands is unpacked and the two significands are multiplied to their full width. The product is shifted by its exponent into a very wide fixed-point register, where it is added or subtracted. The register is split into word-sized limbs held in four banks. Successive products go to the banks in turn, and each bank holds a separate partial sum. A limb carries a few spare bits of headroom, so an add touches only the limbs that the product covers, and no carry has to ripple through the full register width while products stream in.

When a flush is requested, the four partial sums are merged limb by limb with a running carry. The merged value is converted to sign and magnitude, and the leading one is located. The value is then rounded once, to nearest with ties to even, and packed as a floating-point result. A clear empties all banks before a new accumulation. Operands whose exponent field is zero count as zero, and an exponent field of all ones is handled as an ordinary normal value. Each bank can absorb 2^(CARRY_W-1)-1 products before a clear is needed.

Top module: `exact_mac`

## Requirements
- R1: The result of a flush after a single product equals that product rounded to nearest with ties to even. The operand and result layout is sign in the top bit, then EXP_W exponent bits with bias 2^(EXP_W-1)-1, then MAN_W fraction bits.
- R2: After any sequence of products, the result equals the exact sum of all the products rounded once, to nearest with ties to even.
- R3: Negative products are subtracted exactly, and the result carries the sign of the exact sum.
- R4: An operand whose exponent field is zero contributes nothing to the sum.
- R5: A merged sum of exactly zero produces +0.0, the all-zero code.
- R6: A sum whose rounded biased exponent reaches 2^EXP_W-1 produces a signed infinity: exponent field all ones, fraction zero.
- R7: A sum whose biased exponent before rounding is zero or below produces a zero that carries the sign of the sum.
- R8: A product can be accepted on every cycle. Accepted products are written to the NBANK banks in strict rotation, one bank per cycle.
- R9: busy goes high in the cycle after a flush is accepted. It falls in the cycle where out_valid pulses high, and out_valid stays high for that one cycle only.
- R10: in_valid, flush and clear have no effect while busy is high.
- R11: A clear while idle empties the accumulator. A product presented in the same cycle as the clear is dropped.
- R12: A flush leaves the accumulator unchanged. A later flush, with or without further products, reports the running total.
- R13: A product presented in the same cycle as an accepted flush is included in that flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Empty the accumulator (idle only) |
| in_valid | input | 1 | Operand pair present |
| a | input | 1+EXP_W+MAN_W | First operand |
| b | input | 1+EXP_W+MAN_W | Second operand |
| flush | input | 1 | Merge, round and report the sum |
| busy | output | 1 | Flush in progress |
| out_valid | output | 1 | Result valid, one-cycle pulse |
| result | output | 1+EXP_W+MAN_W | Rounded sum |

## Verification
The bench uses an 8-bit format: 4 exponent bits, 3 fraction bits and 8-bit limbs. It sweeps every first-operand code against a set of second operands that includes ±1, the largest and smallest exponents and a zero exponent. This sweep separates errors in exact multiplication from errors in overflow to infinity and in flush to zero. Streams of random signed products run back to back and are checked against an exact integer sum rounded in the bench. These streams expose faults in bank rotation, in the merge carry and in the sign. Directed patterns cover the following cases, each separating one rule from the others:
- exact cancellation;
- a tie that must stay even;
- a product that arrives with the flush;
- products that arrive while busy;
- a product that arrives with a clear;
- repeated flushes without a clear.

// File: rtl/exmac_pkg.sv
// Shared types for the exact multiply-accumulate unit.
package exmac_pkg;
    // Flush sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_MERGE,
        ST_MAG,
        ST_ROUND
    } exmac_state_e;
endpackage

// File: rtl/exmac_mul.sv
// Operand unpack, exact significand product and limb alignment, one register stage.
// Assumes LIMB_W is a power of two; an exponent field of zero makes the product zero.
module exmac_mul #(
    parameter int EXP_W  = 11,
    parameter int MAN_W  = 52,
    parameter int LIMB_W = 32,
    parameter int K      = 5,
    parameter int IW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    in_valid,
    input  logic [EXP_W+MAN_W:0]    a,
    input  logic [EXP_W+MAN_W:0]    b,
    output logic                    s1_v,
    output logic                    s1_neg,
    output logic [IW-1:0]           s1_base,
    output logic [K*LIMB_W-1:0]     s1_chunks
);
    localparam int FW = 1 + EXP_W + MAN_W;
    localparam int PW = 2 * (MAN_W + 1);
    localparam int OW = $clog2(LIMB_W);

    logic [EXP_W-1:0]     ea, eb;
    logic [PW-1:0]        prod;
    logic [EXP_W:0]       pos;
    logic [K*LIMB_W-1:0]  shifted;
    logic                 is_zero;

    // Unpack, multiply exactly and shift to the position inside the base limb.
    always_comb begin
        ea      = a[FW-2 -: EXP_W];
        eb      = b[FW-2 -: EXP_W];
        is_zero = (ea == '0) || (eb == '0);
        prod    = PW'({1'b1, a[MAN_W-1:0]}) * PW'({1'b1, b[MAN_W-1:0]});
        pos     = (EXP_W+1)'(ea) + (EXP_W+1)'(eb) - (EXP_W+1)'(2);
        shifted = (K*LIMB_W)'(prod) << pos[OW-1:0];
    end

    // Register the aligned product for the bank write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s1_v      <= 1'b0;
            s1_neg    <= 1'b0;
            s1_base   <= '0;
            s1_chunks <= '0;
        end else begin
            s1_v      <= in_valid;
            s1_neg    <= a[FW-1] ^ b[FW-1];
            s1_base   <= IW'(pos >> OW);
            s1_chunks <= is_zero ? '0 : shifted;
        end
    end
endmodule

// File: rtl/exmac_bank.sv
// One partial-sum bank: NL signed limbs with CARRY_W spare bits each.
// A write adds or subtracts K limb-wide chunks at limbs base..base+K-1 in one cycle.
module exmac_bank #(
    parameter int LIMB_W  = 32,
    parameter int CARRY_W = 16,
    parameter int NL      = 132,
    parameter int K       = 5,
    parameter int IW      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              we,
    input  logic                              neg,
    input  logic [IW-1:0]                     base,
    input  logic [K*LIMB_W-1:0]               chunks,
    input  logic [IW-1:0]                     rd_idx,
    output logic signed [LIMB_W+CARRY_W-1:0]  rd_data
);
    localparam int SLW = LIMB_W + CARRY_W;

    logic signed [SLW-1:0] limb [NL];

    // Limb-local add or subtract; no carry leaves a limb here.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NL; i++) limb[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NL; i++) begin
                if (i >= int'(base) && i < int'(base) + K) begin
                    if (neg)
                        limb[i] <= limb[i] - $signed({{CARRY_W{1'b0}}, chunks[(i-int'(base))*LIMB_W +: LIMB_W]});
                    else
                        limb[i] <= limb[i] + $signed({{CARRY_W{1'b0}}, chunks[(i-int'(base))*LIMB_W +: LIMB_W]});
                end
            end
        end
    end

    assign rd_data = limb[rd_idx];

    // A clear leaves the lowest and highest limbs at zero.
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (limb[0] == '0 && limb[NL-1] == '0))
        else $error("bank not empty after clear");
endmodule

// File: rtl/exmac_round.sv
// Leading-one search, normalization and round-to-nearest-even of the merged magnitude.
// Assumes mag holds the magnitude and nz flags each nonzero limb. Combinational.
module exmac_round #(
    parameter int EXP_W  = 11,
    parameter int MAN_W  = 52,
    parameter int LIMB_W = 32,
    parameter int NL     = 132
) (
    input  logic                 neg,
    input  logic [NL-1:0]        nz,
    input  logic [NL*LIMB_W-1:0] mag,
    output logic [EXP_W+MAN_W:0] res
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EMAXF = (1 << EXP_W) - 1;
    localparam int WL    = (MAN_W + 2 + LIMB_W - 1) / LIMB_W + 1;
    localparam int WIN   = WL * LIMB_W;

    int               j, lz, p, eb, ebr;
    logic [WIN-1:0]   win, norm;
    logic [MAN_W-1:0] frac;
    logic [MAN_W:0]   mant;
    logic             g, st, rup;

    // Pick the top nonzero limb, normalize a window below it, round once.
    always_comb begin
        j = 0;
        for (int k = 0; k < NL; k++) if (nz[k]) j = k;
        win = '0;
        for (int w = 0; w < WL; w++)
            if (j - w >= 0) win[(WL-w)*LIMB_W-1 -: LIMB_W] = mag[(j-w)*LIMB_W +: LIMB_W];
        lz = 0;
        for (int t = 0; t < LIMB_W; t++) if (win[WIN-LIMB_W+t]) lz = LIMB_W - 1 - t;
        norm = win << lz;
        frac = norm[WIN-2 -: MAN_W];
        g    = norm[WIN-2-MAN_W];
        st   = 1'b0;
        for (int t = 0; t <= WIN-3-MAN_W; t++) st = st | norm[t];
        for (int k = 0; k < NL; k++) if (k < j - WL + 1 && nz[k]) st = 1'b1;
        p    = j * LIMB_W + LIMB_W - 1 - lz;
        eb   = p - (BIAS - 2 + 2 * MAN_W);
        rup  = g & (st | frac[0]);
        mant = {1'b0, frac} + (MAN_W+1)'(rup);
        ebr  = eb + int'(mant[MAN_W]);
        if (!norm[WIN-1])
            res = '0;
        else if (eb <= 0)
            res = {neg, {(EXP_W+MAN_W){1'b0}}};
        else if (ebr >= EMAXF)
            res = {neg, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        else
            res = {neg, EXP_W'(ebr), mant[MAN_W-1:0]};
    end
endmodule

// File: rtl/exact_mac.sv
// Exact multiply-accumulate top: one product per cycle into NBANK rotating partial sums,
// sequential limb merge, sign-magnitude pass and a single final rounding on flush.
// Assumes LIMB_W is a power of two and at most 2^(CARRY_W-1)-1 products per bank between clears.
module exact_mac
    import exmac_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int LIMB_W  = 32,
    parameter int CARRY_W = 16,
    parameter int GUARD_W = 16,
    parameter int NBANK   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  in_valid,
    input  logic [EXP_W+MAN_W:0]  a,
    input  logic [EXP_W+MAN_W:0]  b,
    input  logic                  flush,
    output logic                  busy,
    output logic                  out_valid,
    output logic [EXP_W+MAN_W:0]  result
);
    localparam int FW     = 1 + EXP_W + MAN_W;
    localparam int PW     = 2 * (MAN_W + 1);
    localparam int EMAXF  = (1 << EXP_W) - 1;
    localparam int TOPIDX = 2 * EMAXF - 2 + PW - 1;
    localparam int ACC_W  = TOPIDX + GUARD_W + 2;
    localparam int NL     = (ACC_W + LIMB_W - 1) / LIMB_W;
    localparam int K      = (PW + 2 * LIMB_W - 2) / LIMB_W;
    localparam int IW     = $clog2(NL);
    localparam int RW     = $clog2(NBANK);
    localparam int SLW    = LIMB_W + CARRY_W;
    localparam int SW     = SLW + RW + 1;

    exmac_state_e               state;
    logic [IW-1:0]              idx;
    logic signed [SW-1:0]       cry, sumc;
    logic                       negf, cin;
    logic [LIMB_W:0]            magv;
    logic [LIMB_W-1:0]          mg [NL];
    logic [NL-1:0]              nz;
    logic [NL*LIMB_W-1:0]       mg_flat;
    logic [FW-1:0]              rnd;
    logic                       idle, clr_ok, take;
    logic                       s1_v, s1_neg;
    logic [IW-1:0]              s1_base;
    logic [K*LIMB_W-1:0]        s1_chunks;
    logic [RW-1:0]              rr;
    logic [NBANK-1:0]           bank_we;
    logic signed [SLW-1:0]      rd [NBANK];

    assign idle   = (state == ST_IDLE);
    assign busy   = !idle;
    assign clr_ok = clear && idle;
    assign take   = in_valid && idle && !clear;

    exmac_mul #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LIMB_W(LIMB_W), .K(K), .IW(IW)) u_mul (
        .clk(clk), .rst_n(rst_n), .clr(clr_ok), .in_valid(take), .a(a), .b(b),
        .s1_v(s1_v), .s1_neg(s1_neg), .s1_base(s1_base), .s1_chunks(s1_chunks)
    );

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        assign bank_we[gb] = s1_v && (rr == RW'(gb));
        exmac_bank #(.LIMB_W(LIMB_W), .CARRY_W(CARRY_W), .NL(NL), .K(K), .IW(IW)) u_bank (
            .clk(clk), .rst_n(rst_n), .clr(clr_ok), .we(bank_we[gb]), .neg(s1_neg),
            .base(s1_base), .chunks(s1_chunks), .rd_idx(idx), .rd_data(rd[gb])
        );
    end

    // Round-robin bank pointer, advanced on every bank write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_ok) rr <= '0;
        else if (s1_v)        rr <= rr + RW'(1);
    end

    // Sum of one limb position across all banks plus the carry from below.
    always_comb begin
        sumc = cry;
        for (int bk = 0; bk < NBANK; bk++) sumc = sumc + SW'(rd[bk]);
        magv = {1'b0, (negf ? ~mg[idx] : mg[idx])} + (LIMB_W+1)'(cin);
    end

    for (genvar gl = 0; gl < NL; gl++) begin : g_flat
        assign mg_flat[gl*LIMB_W +: LIMB_W] = mg[gl];
    end

    exmac_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LIMB_W(LIMB_W), .NL(NL)) u_round (
        .neg(negf), .nz(nz), .mag(mg_flat), .res(rnd)
    );

    // Flush sequencer: drain, merge, magnitude, round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            cry       <= '0;
            negf      <= 1'b0;
            cin       <= 1'b0;
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                ST_IDLE:  if (flush && !clear) state <= ST_DRAIN;
                ST_DRAIN: begin
                    idx   <= '0;
                    cry   <= '0;
                    state <= ST_MERGE;
                end
                ST_MERGE: begin
                    cry <= sumc >>> LIMB_W;
                    if (idx == IW'(NL - 1)) begin
                        negf  <= sumc[LIMB_W-1];
                        cin   <= sumc[LIMB_W-1];
                        idx   <= '0;
                        state <= ST_MAG;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
                ST_MAG: begin
                    cin <= magv[LIMB_W];
                    if (idx == IW'(NL - 1)) state <= ST_ROUND;
                    else                    idx   <= idx + IW'(1);
                end
                default: begin
                    result    <= rnd;
                    out_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // Merged limb store and nonzero flags; datapath only, needs no reset.
    always_ff @(posedge clk) begin
        if (state == ST_MERGE) mg[idx] <= sumc[LIMB_W-1:0];
        if (state == ST_MAG) begin
            mg[idx] <= magv[LIMB_W-1:0];
            nz[idx] <= |magv[LIMB_W-1:0];
        end
    end

    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we)) else $error("two banks written");
    assert_rotation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_we && $past(|bank_we) && !$past(clear)) |->
        bank_we == {$past(bank_we[NBANK-2:0]), $past(bank_we[NBANK-1])})
        else $error("bank rotation broken");
    assert_quiet_banks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE || state == ST_MAG || state == ST_ROUND) |-> bank_we == '0)
        else $error("bank written during flush");
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid) else $error("out_valid longer than one cycle");
    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid) else $error("busy fell without result");
    assert_inf_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[FW-2 -: EXP_W] == {EXP_W{1'b1}}) |-> result[MAN_W-1:0] == '0)
        else $error("malformed infinity");
endmodule

// File: tb/tb_exact_mac.sv
module tb_exact_mac;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       in_valid = 1'b0;
    logic       flush = 1'b0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       busy, out_valid;
    logic [7:0] result;

    int     checks = 0;
    int     errors = 0;
    longint ref_acc = 0;

    always #2 clk = ~clk;

    exact_mac #(.EXP_W(4), .MAN_W(3), .LIMB_W(8), .CARRY_W(8), .GUARD_W(16), .NBANK(4)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .a(a), .b(b),
        .flush(flush), .busy(busy), .out_valid(out_valid), .result(result)
    );

    // Exact product in units of 2^-18 (layout: sign, 4 exponent bits, bias 7, 3 fraction bits).
    function automatic longint contrib(input logic [7:0] x, input logic [7:0] y);
        int ex = int'(x[6:3]);
        int ey = int'(y[6:3]);
        longint v;
        if (ex == 0 || ey == 0) return 0;
        v = longint'((8 + int'(x[2:0])) * (8 + int'(y[2:0]))) <<< (ex + ey - 2);
        return (x[7] ^ y[7]) ? -v : v;
    endfunction

    // Round an exact sum to the 8-bit format, nearest with ties to even.
    function automatic logic [7:0] ref_round(input longint s);
        logic   ng = (s < 0);
        longint m = ng ? -s : s;
        longint mant;
        int     p = 0;
        int     e;
        bit     g = 0, st = 0;
        if (s == 0) return 8'h00;
        for (int i = 0; i < 63; i++) if ((m >>> i) & 1) p = i;
        e = p - 11;
        if (e <= 0) return {ng, 7'b0};
        if (p <= 3) mant = m <<< (3 - p);
        else begin
            mant = m >>> (p - 3);
            g    = ((m >>> (p - 4)) & 1) != 0;
            st   = (m & ((longint'(1) <<< (p - 4)) - 1)) != 0;
        end
        if (g && (st || (mant & 1) != 0)) mant = mant + 1;
        if (mant == 16) begin mant = 8; e = e + 1; end
        if (e >= 15) return {ng, 4'hF, 3'b0};
        return {ng, 4'(e), 3'(mant)};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] x, input logic [7:0] y);
        a = x; b = y; in_valid = 1'b1;
        ref_acc += contrib(x, y);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        ref_acc = 0;
    endtask

    task automatic wait_result(input string tag, input logic [7:0] exp);
        int n = 0;
        while (!out_valid && n < 100) begin @(negedge clk); n++; end
        check({tag, " R9 busy low with result"}, {7'b0, busy}, 8'h00);
        check(tag, result, exp);
        @(negedge clk);
        check("R9 out_valid one cycle", {7'b0, out_valid}, 8'h00);
    endtask

    task automatic do_flush(input string tag, input logic [7:0] exp);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R9 busy after flush", {7'b0, busy}, 8'h01);
        wait_result(tag, exp);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] blist [8] = '{8'h38, 8'hB8, 8'h3F, 8'h00, 8'h4D, 8'hC2, 8'h7F, 8'h08};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset busy", {7'b0, busy}, 8'h00);
        check("R9 reset out_valid", {7'b0, out_valid}, 8'h00);

        // R1: every first-operand code against a fixed set of second operands.
        for (int x = 0; x < 256; x++) begin
            for (int k = 0; k < 8; k++) begin
                do_clear();
                push(8'(x), blist[k]);
                do_flush("R1 single product", ref_round(ref_acc));
            end
        end

        // R5 and R3: exact cancellation gives +0.
        do_clear(); push(8'h3F, 8'h4D); push(8'hBF, 8'h4D);
        do_flush("R5 cancel to +0", 8'h00);
        // R3: mixed signs, negative result.
        do_clear(); push(8'h38, 8'h40); push(8'hC8, 8'h38);
        do_flush("R3 negative sum", 8'hC0);
        // R6: overflow to signed infinity.
        do_clear(); push(8'h70, 8'h70);
        do_flush("R6 +inf", 8'h78);
        do_clear(); push(8'hF0, 8'h70);
        do_flush("R6 -inf", 8'hF8);
        // R7: below normal range gives signed zero.
        do_clear(); push(8'h08, 8'h08);
        do_flush("R7 +0 underflow", 8'h00);
        do_clear(); push(8'h88, 8'h08);
        do_flush("R7 -0 underflow", 8'h80);
        // R4: zero exponent operand contributes nothing.
        do_clear(); push(8'h05, 8'h7F); push(8'h38, 8'h38);
        do_flush("R4 zero exponent", 8'h38);
        // R2: ties to even, down then up.
        do_clear(); push(8'h38, 8'h38); push(8'h18, 8'h38);
        do_flush("R2 tie stays even", 8'h38);
        do_clear(); push(8'h39, 8'h38); push(8'h18, 8'h38);
        do_flush("R2 tie rounds up", 8'h3A);
        // R8: eight back-to-back products.
        do_clear();
        for (int i = 0; i < 8; i++) push(8'h38, 8'h38);
        do_flush("R8 back to back", 8'h50);
        // R13: product with the flush is included.
        do_clear(); push(8'h38, 8'h38);
        a = 8'h38; b = 8'h38; in_valid = 1'b1; flush = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0;
        wait_result("R13 product with flush", 8'h40);
        // R10: inputs while busy are ignored.
        do_clear(); push(8'h38, 8'h38);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        a = 8'h70; b = 8'h70; in_valid = 1'b1; flush = 1'b1; clear = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0; clear = 1'b0;
        wait_result("R10 ignored while busy", 8'h38);
        // R12: accumulator persists across flushes.
        do_flush("R12 repeat flush", 8'h38);
        push(8'h38, 8'h38);
        do_flush("R12 continue after flush", 8'h40);
        // R11: clear drops a product in the same cycle.
        push(8'h38, 8'h38); push(8'h38, 8'h38);
        a = 8'h70; b = 8'h70; in_valid = 1'b1; clear = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; clear = 1'b0; ref_acc = 0;
        push(8'h38, 8'h40);
        do_flush("R11 clear empties", 8'h40);

        // R2 and R3: random signed streams, back to back.
        for (int r = 0; r < 300; r++) begin
            int n = 1 + int'($urandom_range(19));
            do_clear();
            for (int i = 0; i < n; i++) push(8'($urandom), 8'($urandom));
            do_flush("R2 random stream", ref_round(ref_acc));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule